// File: doc/BRIEF.md
# Hot-Plug Slot Power Sequencing and Fault Controller

This block holds the digital control for one card slot of a hot-plug power controller. The slot has two rail groups: a main group, covering the 12 V and 3.3 V rails, and an auxiliary rail. The block decides when the gate drivers of each group are enabled. It latches faults for each group separately and drives three active-low indications: a fault flag, a power-good flag and an interrupt request. All of its inputs are asynchronous: the enable levels, a diagnostic force-on input, per-group fault comparator outputs and power-good comparator outputs. Each one passes through a two-flop synchronizer before any edge detection.

A timed current-limit window guards against overcurrent. A rail group may sit in regulated current limit for a programmed number of clock cycles. Only after that window does it trip. The counter restarts whenever the limit condition goes away. Undervoltage and over-temperature trip at once. The main group is turned on by a rising edge of its enable, while the auxiliary rail follows its enable level. Each group's fault latch is cleared by dropping that group's own enable. The diagnostic force-on input turns every rail on and overrides the protections, except auxiliary undervoltage. A control bit can block that input.

A small register port gives access to control, to the current-limit window length and to live status with write-one-to-clear interrupt flags. Reads are registered and return one cycle after the address is presented.

Top module: `slot_pwr_ctrl`

## Requirements
- R1: The main gate enable turns on only after a low-to-high transition of `on_in`. Once enabled, it stays on while `on_in` is high and no fault trips. It turns off whenever `on_in` is low, unless force-on is active.
- R2: The auxiliary gate enable follows the level of `auxen_in`: on while it is high and no auxiliary fault is latched, off while it is low. This applies when force-on is inactive.
- R3: A group's overcurrent input must stay high for the number of consecutive synchronized cycles held in the limit register (address 1, a value of 0 acting as 1) before that group trips. A shorter burst leaves the rail on, and the count restarts from zero after any cycle with the input low. The limit register defaults to the parameter `DEF_LIMIT`.
- R4: An undervoltage or over-temperature input on an enabled group trips that group at once. A trip clears the group's gate enable and sets its fault latch at the same clock edge.
- R5: A low `on_in` clears the main fault latch. A low `auxen_in` clears the auxiliary fault latch.
- R6: `fault_n_o` is low while either fault latch is set. When both are set, it returns high only after both `on_in` and `auxen_in` have been low.
- R7: After a main trip, the main gate stays off for as long as `on_in` stays high. Re-enabling needs `on_in` to go low and then high again.
- R8: While force-on is active (`force_n_in` low and not blocked), both gate enables are on and the overcurrent, over-temperature and main undervoltage trips are ignored. `fault_n_o` and `pwrgd_n_o` are held high. The status register still shows the true commanded and latched state.
- R9: Auxiliary undervoltage turns off the auxiliary gate enable even while force-on is active.
- R10: Control register (address 0) bit 1 set makes `force_n_in` have no effect.
- R11: Every trip sets a sticky flag in the status register (address 2): bit 4 for main, bit 5 for auxiliary. Writing a 1 to a flag bit clears it. `int_n_o` is low while any flag is set and control bit 0 (the mask) is 0.
- R12: `pwrgd_n_o` is low only while force-on is inactive, the main group is commanded on, the auxiliary rail is enabled, and both power-good inputs are high.
- R13: The status register has main commanded on at bit 0, auxiliary on at bit 1, main fault latch at bit 2 and auxiliary fault latch at bit 3. After reset, both gate enables are low, all three flags are high, the control register is 0 and the limit register holds `DEF_LIMIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| on_in | input | 1 | Main group enable, acts on its rising edge |
| auxen_in | input | 1 | Auxiliary rail enable, level sensitive |
| force_n_in | input | 1 | Diagnostic force-on, active low |
| main_oc_in | input | 1 | Main group in current limit |
| main_uv_in | input | 1 | Main group input undervoltage |
| main_ot_in | input | 1 | Main group over-temperature |
| aux_oc_in | input | 1 | Auxiliary rail in current limit |
| aux_uv_in | input | 1 | Auxiliary rail undervoltage |
| aux_ot_in | input | 1 | Auxiliary rail over-temperature |
| main_pg_in | input | 1 | Main rails delivering power |
| aux_pg_in | input | 1 | Auxiliary rail delivering power |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 limit, 2 status |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Registered read data for `reg_addr` |
| main_gate_o | output | 1 | Main group gate enable |
| aux_gate_o | output | 1 | Auxiliary gate enable |
| fault_n_o | output | 1 | Fault flag, active low |
| pwrgd_n_o | output | 1 | Power good, active low |
| int_n_o | output | 1 | Interrupt request, active low |

## Verification
The bench uses the default 16-bit data width, a reset limit of 6 and two synchronizer stages. It then programs the limit register to 4, so the exact trip cycle of the overcurrent window can be checked within a few clocks. At that value, a three-cycle burst lands just short of the window, which exercises the counter restart. The small limit also lets the trip-priority, force-on and latch-clearing orderings all be driven in a short run.

// File: rtl/slot_pkg.sv
package slot_pkg;
  // synchronized input bundle positions
  localparam int S_ON     = 0;
  localparam int S_AUXEN  = 1;
  localparam int S_FORCEN = 2;
  localparam int S_MOC    = 3;
  localparam int S_MUV    = 4;
  localparam int S_MOT    = 5;
  localparam int S_AOC    = 6;
  localparam int S_AUV    = 7;
  localparam int S_AOT    = 8;
  localparam int S_MPG    = 9;
  localparam int S_APG    = 10;
  localparam int S_COUNT  = 11;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_LIMIT = 2'd1,
    REG_STAT  = 2'd2
  } reg_addr_e;

  // status bit positions
  localparam int ST_MAIN_ON  = 0;
  localparam int ST_AUX_ON   = 1;
  localparam int ST_MAIN_FLT = 2;
  localparam int ST_AUX_FLT  = 3;
  localparam int ST_MAIN_IRQ = 4;
  localparam int ST_AUX_IRQ  = 5;
  localparam int ST_BITS     = 6;

  // control bit positions
  localparam int CT_MASK  = 0;
  localparam int CT_BLOCK = 1;
endpackage

// File: rtl/slot_sync.sv
module slot_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/slot_oc_timer.sv
module slot_oc_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic [CW-1:0] limit,
  output logic          expire
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last   = (limit == '0) ? '0 : limit - {{(CW-1){1'b0}}, 1'b1};
  assign expire = active && (cnt_q >= last);

  always_ff @(posedge clk) begin
    if (rst || !active) cnt_q <= '0;
    else if (!expire)   cnt_q <= cnt_q + {{(CW-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/slot_regs.sv
module slot_regs
  import slot_pkg::*;
#(
  parameter int DW = 16,
  parameter int DEF_LIMIT = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          set_main_irq,
  input  logic          set_aux_irq,
  input  logic [3:0]    live_stat,
  output logic          mask,
  output logic          block,
  output logic [DW-1:0] limit,
  output logic [DW-1:0] rdata,
  output logic          int_n
);
  logic [1:0] ctrl_q, ctrl_d;
  logic [DW-1:0] lim_q;
  logic [1:0] irq_q, irq_d, irq_clr;
  logic [ST_BITS-1:0] stat;

  always_comb begin
    ctrl_d  = ctrl_q;
    irq_clr = 2'b00;
    if (wr && addr == REG_CTRL) ctrl_d = wdata[1:0];
    if (wr && addr == REG_STAT) irq_clr = wdata[ST_AUX_IRQ:ST_MAIN_IRQ];
    irq_d = (irq_q & ~irq_clr) | {set_aux_irq, set_main_irq};
  end

  assign stat  = {irq_q, live_stat};
  assign mask  = ctrl_q[CT_MASK];
  assign block = ctrl_q[CT_BLOCK];
  assign limit = lim_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      lim_q  <= DW'(DEF_LIMIT);
      irq_q  <= '0;
      int_n  <= 1'b1;
      rdata  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      irq_q  <= irq_d;
      int_n  <= ~((|irq_d) & ~ctrl_d[CT_MASK]);
      if (wr && addr == REG_LIMIT) lim_q <= wdata;
      case (addr)
        REG_CTRL:  rdata <= DW'(ctrl_q);
        REG_LIMIT: rdata <= lim_q;
        REG_STAT:  rdata <= DW'(stat);
        default:   rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/slot_pwr_ctrl.sv
module slot_pwr_ctrl
  import slot_pkg::*;
#(
  parameter int DW = 16,
  parameter int DEF_LIMIT = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          on_in,
  input  logic          auxen_in,
  input  logic          force_n_in,
  input  logic          main_oc_in,
  input  logic          main_uv_in,
  input  logic          main_ot_in,
  input  logic          aux_oc_in,
  input  logic          aux_uv_in,
  input  logic          aux_ot_in,
  input  logic          main_pg_in,
  input  logic          aux_pg_in,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          main_gate_o,
  output logic          aux_gate_o,
  output logic          fault_n_o,
  output logic          pwrgd_n_o,
  output logic          int_n_o
);
  localparam logic [S_COUNT-1:0] SYNC_RST = S_COUNT'(1) << S_FORCEN;

  logic [S_COUNT-1:0] raw, s;
  logic mask, block;
  logic [DW-1:0] limit;
  logic [1:0] oc_active, oc_exp;

  logic on_d_q, main_req_q, main_flt_q, aux_act_q, aux_flt_q;
  logic force_act, on_rise, main_trip, aux_trip;
  logic main_req_d, main_flt_d, aux_act_d, aux_flt_d;

  assign raw = {aux_pg_in, main_pg_in, aux_ot_in, aux_uv_in, aux_oc_in,
                main_ot_in, main_uv_in, main_oc_in, force_n_in, auxen_in, on_in};

  slot_sync #(.W(S_COUNT), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(s)
  );

  assign force_act    = ~s[S_FORCEN] & ~block;
  assign oc_active[0] = s[S_MOC] & main_req_q & ~force_act;
  assign oc_active[1] = s[S_AOC] & aux_act_q  & ~force_act;

  for (genvar g = 0; g < 2; g++) begin : g_timer
    slot_oc_timer #(.CW(DW)) u_tmr (
      .clk(clk), .rst(rst), .active(oc_active[g]), .limit(limit), .expire(oc_exp[g])
    );
  end

  always_comb begin
    on_rise    = s[S_ON] & ~on_d_q;
    main_trip  = main_req_q & s[S_ON] & ~force_act &
                 (s[S_MUV] | s[S_MOT] | oc_exp[0]);
    main_flt_d = s[S_ON] & (main_flt_q | main_trip);
    main_req_d = s[S_ON] & ~main_trip & (main_req_q | (on_rise & ~main_flt_q));
    aux_trip   = s[S_AUXEN] & ~aux_flt_q &
                 (s[S_AUV] | (~force_act & (s[S_AOT] | oc_exp[1])));
    aux_flt_d  = s[S_AUXEN] & (aux_flt_q | aux_trip);
    aux_act_d  = s[S_AUXEN] & ~aux_flt_d & ~s[S_AUV];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      on_d_q      <= 1'b0;
      main_req_q  <= 1'b0;
      main_flt_q  <= 1'b0;
      aux_act_q   <= 1'b0;
      aux_flt_q   <= 1'b0;
      main_gate_o <= 1'b0;
      aux_gate_o  <= 1'b0;
      fault_n_o   <= 1'b1;
      pwrgd_n_o   <= 1'b1;
    end else begin
      on_d_q      <= s[S_ON];
      main_req_q  <= main_req_d;
      main_flt_q  <= main_flt_d;
      aux_act_q   <= aux_act_d;
      aux_flt_q   <= aux_flt_d;
      main_gate_o <= force_act | main_req_d;
      aux_gate_o  <= ~s[S_AUV] & (force_act | aux_act_d);
      fault_n_o   <= ~(~force_act & (main_flt_d | aux_flt_d));
      pwrgd_n_o   <= ~(~force_act & main_req_d & aux_act_d & s[S_MPG] & s[S_APG]);
    end
  end

  slot_regs #(.DW(DW), .DEF_LIMIT(DEF_LIMIT)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .set_main_irq(main_trip), .set_aux_irq(aux_trip),
    .live_stat({aux_flt_q, main_flt_q, aux_act_q, main_req_q}),
    .mask(mask), .block(block), .limit(limit), .rdata(reg_rdata), .int_n(int_n_o)
  );
endmodule

// File: rtl/slot_pwr_ctrl_chk.sv
module slot_pwr_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic main_gate,
  input logic aux_gate,
  input logic fault_n,
  input logic pwrgd_n,
  input logic int_n,
  input logic main_req,
  input logic main_flt,
  input logic aux_flt,
  input logic aux_uv,
  input logic irq_main,
  input logic irq_aux
);
  p_trip_drop_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(main_flt) |-> $fell(main_req));

  p_fault_src_r6: assert property (@(posedge clk) disable iff (rst)
    !fault_n |-> (main_flt || aux_flt));

  p_lockout_r7: assert property (@(posedge clk) disable iff (rst)
    main_flt |-> !main_req);

  p_aux_uv_off_r9: assert property (@(posedge clk) disable iff (rst)
    aux_uv |=> !aux_gate);

  p_int_src_r11: assert property (@(posedge clk) disable iff (rst)
    !int_n |-> (irq_main || irq_aux));

  p_pwrgd_rails_r12: assert property (@(posedge clk) disable iff (rst)
    !pwrgd_n |-> (main_gate && aux_gate));
endmodule

bind slot_pwr_ctrl slot_pwr_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .main_gate(main_gate_o), .aux_gate(aux_gate_o),
  .fault_n(fault_n_o), .pwrgd_n(pwrgd_n_o), .int_n(int_n_o),
  .main_req(main_req_q), .main_flt(main_flt_q), .aux_flt(aux_flt_q),
  .aux_uv(s[slot_pkg::S_AUV]), .irq_main(u_regs.irq_q[0]), .irq_aux(u_regs.irq_q[1])
);

// File: tb/slot_pwr_ctrl_tb.sv
`timescale 1ns/1ps
module slot_pwr_ctrl_tb_top;
  localparam int DW = 16;
  localparam int DEF_LIMIT = 6;
  localparam int LIM = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic on_in = 0, auxen_in = 0, force_n_in = 1;
  logic main_oc_in = 0, main_uv_in = 0, main_ot_in = 0;
  logic aux_oc_in = 0, aux_uv_in = 0, aux_ot_in = 0;
  logic main_pg_in = 0, aux_pg_in = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [DW-1:0] reg_wdata = 0;
  logic [DW-1:0] reg_rdata;
  logic main_gate_o, aux_gate_o, fault_n_o, pwrgd_n_o, int_n_o;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  slot_pwr_ctrl #(.DW(DW), .DEF_LIMIT(DEF_LIMIT), .SYNC_STAGES(2)) dut_i (.*);

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [DW-1:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [DW-1:0] d);
    reg_addr = a;
    tick(1);
    d = reg_rdata;
  endtask

  task automatic power_up();
    on_in = 0; auxen_in = 0;
    tick(5);
    on_in = 1; auxen_in = 1;
    tick(6);
    wr_reg(2, 16'h0030);
    tick(2);
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    chk("R13 main gate reset", main_gate_o, 0);
    chk("R13 aux gate reset", aux_gate_o, 0);
    chk("R13 fault_n reset", fault_n_o, 1);
    chk("R13 pwrgd_n reset", pwrgd_n_o, 1);
    chk("R13 int_n reset", int_n_o, 1);
    rd_reg(1, d); chk("R13 limit default", d, DEF_LIMIT);
    rd_reg(0, d); chk("R13 ctrl default", d, 0);
  endtask

  task automatic t_enable();
    logic [DW-1:0] d;
    main_pg_in = 1; aux_pg_in = 1;
    power_up();
    chk("R1 main on after rise", main_gate_o, 1);
    chk("R2 aux on with level", aux_gate_o, 1);
    chk("R12 pwrgd low all good", pwrgd_n_o, 0);
    rd_reg(2, d); chk("R13 status on bits", d, 16'h0003);
    aux_pg_in = 0; tick(5);
    chk("R12 pwrgd released on aux pg loss", pwrgd_n_o, 1);
    aux_pg_in = 1;
    auxen_in = 0; tick(5);
    chk("R2 aux off when level low", aux_gate_o, 0);
    chk("R12 pwrgd released aux off", pwrgd_n_o, 1);
    chk("R1 main stays on", main_gate_o, 1);
    auxen_in = 1; tick(5);
    chk("R2 aux back on level high", aux_gate_o, 1);
    on_in = 0; tick(5);
    chk("R1 main off on low", main_gate_o, 0);
  endtask

  task automatic t_oc_timer();
    logic [DW-1:0] d;
    power_up();
    wr_reg(1, LIM);
    main_oc_in = 1; tick(LIM - 1); main_oc_in = 0; tick(1);
    main_oc_in = 1; tick(LIM - 1); main_oc_in = 0; tick(5);
    chk("R3 short bursts do not trip", main_gate_o, 1);
    chk("R3 short bursts no fault", fault_n_o, 1);
    main_oc_in = 1;
    tick(LIM + 1);
    chk("R3 still on before window end", main_gate_o, 1);
    tick(1);
    chk("R3 trips at window end", main_gate_o, 0);
    chk("R4 fault latched same edge", fault_n_o, 0);
    main_oc_in = 0; tick(10);
    chk("R7 stays off while on high", main_gate_o, 0);
    rd_reg(2, d); chk("R13 main latch bit", d[2], 1);
    on_in = 0; tick(5);
    rd_reg(2, d); chk("R5 on low clears main latch", d[2], 0);
    chk("R5 fault released", fault_n_o, 1);
    on_in = 1; tick(6);
    chk("R7 re-enable after low-high", main_gate_o, 1);
  endtask

  task automatic t_uv_ot();
    logic [DW-1:0] d;
    power_up();
    main_ot_in = 1; tick(1); main_ot_in = 0; tick(5);
    chk("R4 main ot trips", main_gate_o, 0);
    chk("R4 aux unaffected", aux_gate_o, 1);
    aux_uv_in = 1; tick(1); aux_uv_in = 0; tick(5);
    chk("R4 aux uv trips", aux_gate_o, 0);
    rd_reg(2, d); chk("R4 both latches and flags", d, 16'h003C);
    auxen_in = 0; tick(5);
    rd_reg(2, d); chk("R5 auxen low clears aux latch", d[3], 0);
    chk("R6 fault held by main latch", fault_n_o, 0);
    on_in = 0; tick(5);
    chk("R6 fault released after both low", fault_n_o, 1);
  endtask

  task automatic t_fault_both();
    power_up();
    main_uv_in = 1; tick(1); main_uv_in = 0;
    aux_ot_in = 1; tick(1); aux_ot_in = 0; tick(5);
    chk("R6 fault low both latched", fault_n_o, 0);
    on_in = 0; tick(5);
    chk("R6 fault still low aux latched", fault_n_o, 0);
    auxen_in = 0; tick(5);
    chk("R6 fault released", fault_n_o, 1);
  endtask

  task automatic t_int();
    logic [DW-1:0] d;
    power_up();
    chk("R11 int idle", int_n_o, 1);
    main_uv_in = 1; tick(1); main_uv_in = 0; tick(5);
    chk("R11 int on trip", int_n_o, 0);
    on_in = 0; tick(5);
    chk("R11 int sticky after latch clear", int_n_o, 0);
    rd_reg(2, d); chk("R11 main flag set", d[4], 1);
    wr_reg(2, 16'h0010); tick(1);
    chk("R11 w1c releases int", int_n_o, 1);
    rd_reg(2, d); chk("R11 flag cleared", d[4], 0);
    wr_reg(0, 16'h0001);
    power_up();
    main_uv_in = 1; tick(1); main_uv_in = 0; tick(5);
    chk("R11 masked int stays high", int_n_o, 1);
    rd_reg(2, d); chk("R11 masked flag still set", d[4], 1);
    wr_reg(2, 16'h0030);
    wr_reg(0, 16'h0000); tick(2);
    chk("R11 int idle after clear", int_n_o, 1);
  endtask

  task automatic t_force();
    logic [DW-1:0] d;
    on_in = 0; auxen_in = 0; tick(5);
    force_n_in = 0; tick(5);
    chk("R8 main forced on", main_gate_o, 1);
    chk("R8 aux forced on", aux_gate_o, 1);
    rd_reg(2, d); chk("R8 status shows true off", d[1:0], 0);
    aux_uv_in = 1; tick(5);
    chk("R9 aux uv wins over force", aux_gate_o, 0);
    chk("R9 main still forced", main_gate_o, 1);
    aux_uv_in = 0; tick(5);
    on_in = 1; auxen_in = 1; tick(6);
    main_ot_in = 1; main_oc_in = 1; tick(LIM + 6);
    chk("R8 protections ignored", main_gate_o, 1);
    chk("R8 fault released", fault_n_o, 1);
    chk("R8 pwrgd released", pwrgd_n_o, 1);
    rd_reg(2, d); chk("R8 status true state", d[3:0], 4'h3);
    main_ot_in = 0; main_oc_in = 0; tick(2);
    force_n_in = 1; tick(5);
    chk("R12 pwrgd after force release", pwrgd_n_o, 0);
    wr_reg(0, 16'h0002);
    on_in = 0; auxen_in = 0; tick(5);
    force_n_in = 0; tick(5);
    chk("R10 blocked force main off", main_gate_o, 0);
    chk("R10 blocked force aux off", aux_gate_o, 0);
    force_n_in = 1;
    wr_reg(0, 16'h0000); tick(3);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(2);
    t_reset();
    t_enable();
    t_oc_timer();
    t_uv_ot();
    t_fault_both();
    t_int();
    t_force();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule